// File: doc/BRIEF.md
# Genotype Truth-Table Error Scorer

This block scores one feed-forward logic graph against a target truth table. The graph is held in a small register file. Each node record carries a three-bit gate code and two source indices, and a separate table holds one source index for each circuit output. A source index below the primary input count picks a primary input. A larger index picks a node's result, so node `j` may only use sources below `N_IN + j`. Nodes that no output reaches still get evaluated, but they cannot change the score.

After `start`, the engine steps through every primary input combination in ascending order. For each combination it evaluates the nodes one per cycle, in node order, and keeps each result in a per-combination value vector. One compare cycle follows, in which it XORs the selected output bits against the target row fetched from an external memory and adds the number of mismatches to a running sum. When the last combination has been compared, `done` pulses and `err_count` holds the total Hamming distance. A zero count means the graph is functionally correct. A graph with a source that is not strictly earlier, or with any other illegal gene, scores the worst possible count instead.

Top module: `cgp_eval`

## Requirements
- R1: After reset, `busy`, `done` and `err_count` are all zero.
- R2: A `start` sampled while idle raises `busy` at that edge. `done` then rises exactly 2^N_IN × (N_NODE+1) clock edges later, and `busy` falls on the same edge.
- R3: `done` is high for exactly one cycle. `err_count` carries the new score in that cycle and keeps it until the next run completes.
- R4: A `start` asserted while `busy` is high has no effect: the running sweep keeps its timing and its score.
- R5: A source index i < N_IN selects primary input bit i, which is bit i of the current combination (`tgt_addr`). An index i ≥ N_IN selects the result of node i − N_IN. Output pointers decode the same way.
- R6: Gate codes: 0 AND, 1 NAND, 2 XOR, 3 OR, 4 NOR, 5 XNOR, 6 inverter of the first source. Code 7 is illegal.
- R7: An inverter node ignores its second source index, even when that index would otherwise be illegal.
- R8: `err_count` is the sum over all combinations c of the number of output positions k where output k differs from bit k of the target row read at `tgt_addr` = c.
- R9: If any node has gate code 7, a first source ≥ N_IN + j, or a non-inverter second source ≥ N_IN + j (j = node position), or any output pointer is ≥ N_IN + N_NODE, then `err_count` = 2^N_IN × N_OUT.
- R10: Loaded genes persist across runs, and a write to a node record is visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_we | input | 1 | Write strobe for a node record |
| node_addr | input | NODE_AW | Node position to write |
| node_func | input | 3 | Gate code for the node |
| node_in0 | input | IDX_W | First source index |
| node_in1 | input | IDX_W | Second source index |
| optr_we | input | 1 | Write strobe for an output pointer |
| optr_addr | input | OUT_AW | Output position to write |
| optr_idx | input | IDX_W | Source index for that output |
| start | input | 1 | Begin a scoring sweep (ignored while busy) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when the score is ready |
| tgt_addr | output | N_IN | Current input combination and target row address |
| tgt_rdata | input | N_OUT | Target row, read combinationally from `tgt_addr` |
| err_count | output | ERR_W | Accumulated Hamming distance |

## Verification
The bench builds the engine with three primary inputs, four outputs and eight nodes. With these sizes every sweep has eight combinations and a 72-cycle latency, and the worst score is 32. At this size a bench-side graph model can score dozens of random legal genotypes and whole random target tables, and directed cases can still cover every gate code, each illegal-gene form, an inverter carrying a wild second index, and a restart pulse in the middle of a sweep.

// File: rtl/cgp_eval_pkg.sv
package cgp_eval_pkg;
  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_NAND = 3'd1,
    FN_XOR  = 3'd2,
    FN_OR   = 3'd3,
    FN_NOR  = 3'd4,
    FN_XNOR = 3'd5,
    FN_INV  = 3'd6,
    FN_RSVD = 3'd7
  } cgp_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_CMP  = 2'd2
  } cgp_st_e;
endpackage

// File: rtl/cgp_gate.sv
module cgp_gate
  import cgp_eval_pkg::*;
(
  input  logic [2:0] fn,
  input  logic       a,
  input  logic       b,
  output logic       y,
  output logic       bad_fn
);
  always_comb begin
    bad_fn = 1'b0;
    unique case (cgp_fn_e'(fn))
      FN_AND:  y = a & b;
      FN_NAND: y = ~(a & b);
      FN_XOR:  y = a ^ b;
      FN_OR:   y = a | b;
      FN_NOR:  y = ~(a | b);
      FN_XNOR: y = ~(a ^ b);
      FN_INV:  y = ~a;
      default: begin
        y      = 1'b0;
        bad_fn = 1'b1;
      end
    endcase
  end

  // R6 / R9: only the reserved code is flagged
  always_comb begin
    if (fn != 3'd7) assert (!bad_fn) else $error("a_r6_code_legal");
  end
endmodule

// File: rtl/cgp_geno_store.sv
module cgp_geno_store #(
  parameter int N_NODE  = 64,
  parameter int N_OUT   = 16,
  parameter int IDX_W   = 7,
  parameter int NODE_AW = 6,
  parameter int OUT_AW  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    node_we,
  input  logic [NODE_AW-1:0]      node_addr,
  input  logic [2:0]              node_func,
  input  logic [IDX_W-1:0]        node_in0,
  input  logic [IDX_W-1:0]        node_in1,
  input  logic                    optr_we,
  input  logic [OUT_AW-1:0]       optr_addr,
  input  logic [IDX_W-1:0]        optr_idx,
  input  logic [NODE_AW-1:0]      rd_node,
  output logic [2:0]              rd_func,
  output logic [IDX_W-1:0]        rd_in0,
  output logic [IDX_W-1:0]        rd_in1,
  output logic [N_OUT*IDX_W-1:0]  optr_flat
);
  logic [2:0]       fn_q  [N_NODE];
  logic [IDX_W-1:0] in0_q [N_NODE];
  logic [IDX_W-1:0] in1_q [N_NODE];
  logic [IDX_W-1:0] op_q  [N_OUT];

  logic node_wr_ok, optr_wr_ok;
  assign node_wr_ok = node_we && (32'(node_addr) < N_NODE);
  assign optr_wr_ok = optr_we && (32'(optr_addr) < N_OUT);

  always_ff @(posedge clk) begin
    if (node_wr_ok) begin
      fn_q[node_addr]  <= node_func;
      in0_q[node_addr] <= node_in0;
      in1_q[node_addr] <= node_in1;
    end
  end

  always_ff @(posedge clk) begin
    if (optr_wr_ok) op_q[optr_addr] <= optr_idx;
  end

  always_comb begin
    rd_func = 3'd0;
    rd_in0  = '0;
    rd_in1  = '0;
    if (32'(rd_node) < N_NODE) begin
      rd_func = fn_q[rd_node];
      rd_in0  = in0_q[rd_node];
      rd_in1  = in1_q[rd_node];
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_optr
    assign optr_flat[k*IDX_W +: IDX_W] = op_q[k];
  end

  // R10: a node write lands in the register file
  a_r10_node_write: assert property (@(posedge clk) disable iff (!rst_n)
    node_wr_ok |=> (fn_q[$past(node_addr)] == $past(node_func)) &&
                   (in0_q[$past(node_addr)] == $past(node_in0)));
endmodule

// File: rtl/cgp_seq.sv
module cgp_seq
  import cgp_eval_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_NODE  = 64,
  parameter int NODE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               eval_en,
  output logic               cmp_en,
  output logic               last_cmp,
  output logic               clr,
  output logic [NODE_AW-1:0] node_idx,
  output logic [N_IN-1:0]    combo
);
  localparam logic [NODE_AW-1:0] LAST_NODE = NODE_AW'(N_NODE - 1);

  cgp_st_e            st_q, st_d;
  logic [NODE_AW-1:0] node_q, node_d;
  logic [N_IN-1:0]    combo_q, combo_d;
  logic               done_q, done_d;

  assign busy     = (st_q != ST_IDLE);
  assign eval_en  = (st_q == ST_EVAL);
  assign cmp_en   = (st_q == ST_CMP);
  assign last_cmp = cmp_en && (combo_q == '1);
  assign clr      = (st_q == ST_IDLE) && start;
  assign node_idx = node_q;
  assign combo    = combo_q;
  assign done     = done_q;

  always_comb begin
    st_d    = st_q;
    node_d  = node_q;
    combo_d = combo_q;
    done_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_EVAL;
          node_d  = '0;
          combo_d = '0;
        end
      end
      ST_EVAL: begin
        if (node_q == LAST_NODE) st_d = ST_CMP;
        else                     node_d = node_q + 1'b1;
      end
      ST_CMP: begin
        if (combo_q == '1) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d    = ST_EVAL;
          node_d  = '0;
          combo_d = combo_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      node_q  <= '0;
      combo_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      node_q  <= node_d;
      combo_q <= combo_d;
      done_q  <= done_d;
    end
  end

  // R3: done is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: done only after the sweep has ended
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R4: a start during a sweep does not restart the combination count
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_cmp) |=> busy && (combo_q >= $past(combo_q)));
  // R2: node counter stays in range while sweeping
  a_r2_node_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(node_q) < N_NODE));
endmodule

// File: rtl/cgp_eval.sv
module cgp_eval #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 16,
  parameter int N_NODE = 64,
  localparam int N_SIG   = N_IN + N_NODE,
  localparam int IDX_W   = $clog2(N_SIG),
  localparam int NODE_AW = (N_NODE > 1) ? $clog2(N_NODE) : 1,
  localparam int OUT_AW  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int N_COMB  = 1 << N_IN,
  localparam int ERR_MAX = N_COMB * N_OUT,
  localparam int ERR_W   = $clog2(ERR_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               node_we,
  input  logic [NODE_AW-1:0] node_addr,
  input  logic [2:0]         node_func,
  input  logic [IDX_W-1:0]   node_in0,
  input  logic [IDX_W-1:0]   node_in1,
  input  logic               optr_we,
  input  logic [OUT_AW-1:0]  optr_addr,
  input  logic [IDX_W-1:0]   optr_idx,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [N_IN-1:0]    tgt_addr,
  input  logic [N_OUT-1:0]   tgt_rdata,
  output logic [ERR_W-1:0]   err_count
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic               eval_en, cmp_en, last_cmp, clr;
  logic [NODE_AW-1:0] node_idx;
  logic [N_IN-1:0]    combo;

  cgp_seq #(.N_IN(N_IN), .N_NODE(N_NODE), .NODE_AW(NODE_AW)) seq_i (
    .clk(clk), .rst_n(rst_n_s), .start(start), .busy(busy), .done(done),
    .eval_en(eval_en), .cmp_en(cmp_en), .last_cmp(last_cmp), .clr(clr),
    .node_idx(node_idx), .combo(combo)
  );

  logic [2:0]             cur_fn;
  logic [IDX_W-1:0]       cur_in0, cur_in1;
  logic [N_OUT*IDX_W-1:0] optr_flat;

  cgp_geno_store #(.N_NODE(N_NODE), .N_OUT(N_OUT), .IDX_W(IDX_W),
                   .NODE_AW(NODE_AW), .OUT_AW(OUT_AW)) store_i (
    .clk(clk), .rst_n(rst_n_s),
    .node_we(node_we), .node_addr(node_addr), .node_func(node_func),
    .node_in0(node_in0), .node_in1(node_in1),
    .optr_we(optr_we), .optr_addr(optr_addr), .optr_idx(optr_idx),
    .rd_node(node_idx), .rd_func(cur_fn), .rd_in0(cur_in0), .rd_in1(cur_in1),
    .optr_flat(optr_flat)
  );

  // signal vector: primary inputs in the low bits, node results above
  logic [N_NODE-1:0] nval_q;
  logic [N_SIG-1:0]  sig;
  assign sig = {nval_q, combo};

  function automatic logic pick(input logic [N_SIG-1:0] s,
                                input logic [IDX_W-1:0] i);
    if (32'(i) < N_SIG) return s[i];
    return 1'b0;
  endfunction

  logic gate_a, gate_b, gate_y, gate_bad;
  assign gate_a = pick(sig, cur_in0);
  assign gate_b = pick(sig, cur_in1);

  cgp_gate gate_i (.fn(cur_fn), .a(gate_a), .b(gate_b),
                   .y(gate_y), .bad_fn(gate_bad));

  // a source must be strictly earlier than the node using it
  logic [IDX_W:0] src_lim;
  logic           node_bad;
  assign src_lim  = (IDX_W+1)'(N_IN) + (IDX_W+1)'(node_idx);
  assign node_bad = gate_bad ||
                    ({1'b0, cur_in0} >= src_lim) ||
                    ((cur_fn != 3'd6) && ({1'b0, cur_in1} >= src_lim));

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     nval_q <= '0;
    else if (eval_en) nval_q[node_idx] <= gate_y;
  end

  // compare stage
  logic [N_OUT-1:0] obit, optr_bad;
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [IDX_W-1:0] p;
    assign p           = optr_flat[k*IDX_W +: IDX_W];
    assign obit[k]     = pick(sig, p);
    assign optr_bad[k] = (32'(p) >= N_SIG);
  end

  logic [N_OUT-1:0] miss;
  logic [ERR_W-1:0] miss_n;
  assign miss = obit ^ tgt_rdata;
  always_comb begin
    miss_n = '0;
    for (int k = 0; k < N_OUT; k++) miss_n = miss_n + ERR_W'(miss[k]);
  end

  logic [ERR_W-1:0] acc_q, acc_d, err_q, err_d;
  logic             bad_q, bad_d;

  always_comb begin
    acc_d = acc_q;
    bad_d = bad_q;
    err_d = err_q;
    if (clr) begin
      acc_d = '0;
      bad_d = 1'b0;
    end else begin
      if (eval_en && node_bad) bad_d = 1'b1;
      if (cmp_en) begin
        acc_d = acc_q + miss_n;
        if (|optr_bad) bad_d = 1'b1;
      end
      if (last_cmp) err_d = bad_d ? ERR_W'(ERR_MAX) : acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_q <= '0;
      bad_q <= 1'b0;
      err_q <= '0;
    end else begin
      acc_q <= acc_d;
      bad_q <= bad_d;
      err_q <= err_d;
    end
  end

  assign tgt_addr  = combo;
  assign err_count = err_q;

  // R9: score never exceeds the worst case
  a_r9_err_bound: assert property (@(posedge clk) disable iff (!rst_n_s)
    32'(err_count) <= ERR_MAX);
  // R3: score is held between completions
  a_r3_err_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !done |-> $stable(err_count));
  // R8: the running sum only grows during a sweep
  a_r8_acc_monotone: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && $past(busy)) |-> (acc_q >= $past(acc_q)));
endmodule

// File: tb/cgp_eval_tb_top.sv
module cgp_eval_tb_top;
  localparam int NI = 3, NO = 4, NN = 8;
  localparam int NS = NI + NN;
  localparam int IW = $clog2(NS);
  localparam int EW = $clog2((1 << NI) * NO + 1);
  localparam int MAXE = (1 << NI) * NO;
  localparam int LAT = (1 << NI) * (NN + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, node_we, optr_we, start;
  logic [2:0] node_addr;
  logic [2:0] node_func;
  logic [IW-1:0] node_in0, node_in1, optr_idx;
  logic [1:0] optr_addr;
  logic busy, done;
  logic [NI-1:0] tgt_addr;
  logic [NO-1:0] tgt_rdata;
  logic [EW-1:0] err_count;

  logic [NO-1:0] tgt_mem [1 << NI];
  assign tgt_rdata = tgt_mem[tgt_addr];

  cgp_eval #(.N_IN(NI), .N_OUT(NO), .N_NODE(NN)) dut_i (
    .clk(clk), .rst_n(rst_n), .node_we(node_we), .node_addr(node_addr),
    .node_func(node_func), .node_in0(node_in0), .node_in1(node_in1),
    .optr_we(optr_we), .optr_addr(optr_addr), .optr_idx(optr_idx),
    .start(start), .busy(busy), .done(done), .tgt_addr(tgt_addr),
    .tgt_rdata(tgt_rdata), .err_count(err_count)
  );

  int total = 0, bad = 0;
  int gf [NN], g0 [NN], g1 [NN], op [NO];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_node(input int j, input int f, input int a, input int b);
    @(negedge clk);
    node_we = 1'b1; node_addr = 3'(j); node_func = 3'(f);
    node_in0 = IW'(a); node_in1 = IW'(b);
    gf[j] = f; g0[j] = a; g1[j] = b;
    @(negedge clk);
    node_we = 1'b0;
  endtask

  task automatic set_out(input int k, input int idx);
    @(negedge clk);
    optr_we = 1'b1; optr_addr = 2'(k); optr_idx = IW'(idx); op[k] = idx;
    @(negedge clk);
    optr_we = 1'b0;
  endtask

  function automatic int model_err();
    logic [NS-1:0] v;
    int e = 0;
    for (int j = 0; j < NN; j++) begin
      if (gf[j] == 7 || g0[j] >= NI + j || (gf[j] != 6 && g1[j] >= NI + j))
        return MAXE;
    end
    for (int k = 0; k < NO; k++) if (op[k] >= NS) return MAXE;
    for (int c = 0; c < (1 << NI); c++) begin
      logic a, b, y;
      v = '0;
      for (int i = 0; i < NI; i++) v[i] = c[i];
      for (int j = 0; j < NN; j++) begin
        a = v[g0[j]];
        b = (g1[j] < NS) ? v[g1[j]] : 1'b0;
        case (gf[j])
          0: y = a & b;   1: y = ~(a & b); 2: y = a ^ b;
          3: y = a | b;   4: y = ~(a | b); 5: y = ~(a ^ b);
          default: y = ~a;
        endcase
        v[NI + j] = y;
      end
      for (int k = 0; k < NO; k++) e += int'(v[op[k]] ^ tgt_mem[c][k]);
    end
    return e;
  endfunction

  // run a sweep; returns latency in cycles and final score
  task automatic run(output int lat, output int score, input int poke_at);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
      if (lat == poke_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    score = int'(err_count);
  endtask

  task automatic run_chk(input string tag, input int exp);
    int lat, sc;
    run(lat, sc, -1);
    chk(lat == LAT, "R2 latency", lat, LAT);
    chk(sc == exp, tag, sc, exp);
    @(negedge clk);
    chk(!done, "R3 done one cycle", int'(done), 0);
    chk(int'(err_count) == exp, "R3 score held", int'(err_count), exp);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, sc, e;
    rst_n = 1'b0; node_we = 0; optr_we = 0; start = 0;
    node_addr = 0; node_func = 0; node_in0 = 0; node_in1 = 0;
    optr_addr = 0; optr_idx = 0;
    for (int c = 0; c < (1 << NI); c++) tgt_mem[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && err_count == 0, "R1 reset state",
        int'({busy, done}) + int'(err_count), 0);

    // R5: outputs are inputs 0,1,2 and node 0 = AND(in0,in1)
    for (int j = 0; j < NN; j++) set_node(j, 0, 0, 1);
    set_out(0, 0); set_out(1, 1); set_out(2, 2); set_out(3, NI);
    for (int c = 0; c < (1 << NI); c++)
      tgt_mem[c] = {c[0] & c[1], c[2], c[1], c[0]};
    run_chk("R5 source decode", 0);
    // R8: flip three target bits
    tgt_mem[1][0] = ~tgt_mem[1][0];
    tgt_mem[5][3] = ~tgt_mem[5][3];
    tgt_mem[7][2] = ~tgt_mem[7][2];
    run_chk("R8 hamming three", 3);
    // R8: all bits wrong
    for (int c = 0; c < (1 << NI); c++)
      tgt_mem[c] = ~{c[0] & c[1], c[2], c[1], c[0]};
    run_chk("R8 hamming all", MAXE);

    // R6: every gate code on inputs 0 and 1
    for (int j = 0; j < 7; j++) set_node(j, j, 0, 1);
    set_node(7, 6, 2, 0);
    for (int grp = 0; grp < 2; grp++) begin
      for (int k = 0; k < NO; k++) set_out(k, NI + grp * 4 + k);
      for (int c = 0; c < (1 << NI); c++) begin
        logic a, b;
        a = c[0]; b = c[1];
        if (grp == 0) tgt_mem[c] = {a | b, a ^ b, ~(a & b), a & b};
        else          tgt_mem[c] = {~c[2], ~a, ~(a ^ b), ~(a | b)};
      end
      run_chk("R6 gate codes", 0);
    end

    // R7: inverter with an out-of-range second index stays legal
    set_node(0, 6, 1, NS + 3);
    set_out(0, NI);
    for (int c = 0; c < (1 << NI); c++) tgt_mem[c][0] = ~c[1];
    e = model_err();
    run_chk("R7 inverter ignores in1", e);
    chk(e < MAXE, "R7 model sanity", e, 0);

    // R9: forward reference, self reference, reserved code, bad pointer
    set_node(3, 0, NI + 4, 0);
    run_chk("R9 forward source", MAXE);
    set_node(3, 2, 0, NI + 3);
    run_chk("R9 self source", MAXE);
    set_node(3, 7, 0, 1);
    run_chk("R9 reserved code", MAXE);
    set_node(3, 0, 0, 1);
    set_out(2, NS);
    run_chk("R9 pointer range", MAXE);
    set_out(2, 0);
    e = model_err();
    run_chk("R10 genes persist", e);

    // R4: restart pulse mid-sweep
    run(lat, sc, 20);
    chk(lat == LAT, "R4 latency unchanged", lat, LAT);
    chk(sc == e, "R4 score unchanged", sc, e);
    @(negedge clk);
    chk(!busy, "R4 no new sweep", int'(busy), 0);

    // R8: random legal genotypes and targets
    for (int t = 0; t < 40; t++) begin
      for (int j = 0; j < NN; j++)
        set_node(j, $urandom_range(0, 6), $urandom_range(0, NI + j - 1),
                 $urandom_range(0, NI + j - 1));
      for (int k = 0; k < NO; k++) set_out(k, $urandom_range(0, NS - 1));
      for (int c = 0; c < (1 << NI); c++) tgt_mem[c] = NO'($urandom);
      run_chk("R8 random genotype", model_err());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule